// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block holds a small set of recent page translations and answers lookups in the same cycle. A lookup presents a 20-bit virtual page number. Every stored entry compares against it in parallel, and the block returns a hit flag together with the cached frame number, the write-permission bit and the user-access bit. On a miss, the surrounding walker fetches the translation and pushes it back through the fill port. An instruction-side cache and a data-side cache are built by instantiating the block twice.

Two invalidation controls keep the cache coherent with the page tables. A page-invalidate pulse removes the one entry whose page number matches a supplied address. A pulse raised when software rewrites the root page-table register clears every entry.

The lookup path has no back-pressure: it is combinational and is always accepted. The fill port is valid/ready. A fill transfers on a rising clock edge when both `fill_valid` and `fill_ready` are high. `fill_ready` drops in any cycle in which an invalidate or a root rewrite is requested. A pending fill should hold its payload until it is accepted.

Top module: `xlc_tlb`

## Requirements
- R1: After reset no entry is valid, so every lookup reports a miss.
- R2: A lookup with `lk_valid` high returns the result in the same cycle. A page filled at one clock edge hits from the next cycle on, with the frame number, write bit and user bit that were written. With `lk_valid` low, `lk_hit` is 0.
- R3: A lookup of a page that is not present reports `lk_hit`=0, with `lk_pfn`, `lk_wr` and `lk_usr` all 0.
- R4: A fill of a new page goes to the lowest-numbered invalid entry, so no valid page is displaced while a free entry exists.
- R5: When every entry is valid, a fill of a new page replaces the entry at a round-robin pointer. The pointer starts at entry 0 after reset, advances by one only on such a replacement, and wraps after the last entry.
- R6: A fill whose page number matches a valid entry overwrites that entry in place. A page is never held in two entries, and the other entries are untouched.
- R7: A page-invalidate removes only the entry that matches `inv_vpn`. All other pages keep hitting.
- R8: A root rewrite (`root_wr`) clears all entries. From the next cycle every lookup misses.
- R9: A lookup in the same cycle as a page-invalidate of the same page reports a miss. A lookup in the same cycle as `root_wr` also reports a miss.
- R10: `fill_ready` is 0 in any cycle with `inv_page` or `root_wr` high. A fill offered in such a cycle is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request qualifier |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_hit | output | 1 | Translation found (same cycle) |
| lk_pfn | output | 20 | Frame number of the hit, 0 on miss |
| lk_wr | output | 1 | Write allowed on the hit page |
| lk_usr | output | 1 | User access allowed on the hit page |
| fill_valid | input | 1 | Fill payload offered |
| fill_ready | output | 1 | Fill accepted at the next edge |
| fill_vpn | input | 20 | Page number being inserted |
| fill_pfn | input | 20 | Frame number being inserted |
| fill_wr | input | 1 | Write permission being inserted |
| fill_usr | input | 1 | User permission being inserted |
| inv_page | input | 1 | Invalidate the entry matching inv_vpn |
| inv_vpn | input | 20 | Page number to invalidate |
| root_wr | input | 1 | Root register rewritten: clear all entries |

## Verification
The hardest situation to reach from the ports is round-robin replacement after entries have been freed out of order. The pointer only moves on a full-cache replacement, so its position has to be inferred from which page disappears. The stimulus therefore runs a reduced four-entry configuration. It mixes fills, duplicate refills, single invalidations and flushes, and after every operation it sweeps a set of page numbers. Each sweep is compared with an arithmetic occupancy model, so the exact victim choice shows up as one specific page going missing.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  typedef enum logic [1:0] {
    SLOT_SAME = 2'd0,
    SLOT_FREE = 2'd1,
    SLOT_EVICT = 2'd2
  } slot_kind_e;

  typedef struct packed {
    logic wr;
    logic usr;
  } perm_t;
endpackage

// File: rtl/xlc_match.sv
module xlc_match #(
  parameter int N  = 64,
  parameter int VW = 20
) (
  input  logic [N-1:0]  valid,
  input  logic [VW-1:0] tags [N],
  input  logic [VW-1:0] key,
  output logic [N-1:0]  hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/xlc_first_one.sv
module xlc_first_one #(
  parameter int N  = 64,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/xlc_rr_victim.sv
module xlc_rr_victim #(
  parameter int N  = 64,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [IW-1:0] ptr
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (advance) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/xlc_tlb.sv
module xlc_tlb #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_wr,
  output logic             lk_usr,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_wr,
  input  logic             fill_usr,
  input  logic             inv_page,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             root_wr
);
  import xlc_pkg::*;

  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  perm_t              perm_q [ENTRIES];

  logic [ENTRIES-1:0] hit_vec, dup_vec, kill_vec;
  logic               dup_found, free_found, fill_fire, evict;
  logic [IW-1:0]      dup_idx, free_idx, rr_ptr, tgt;
  slot_kind_e         kind;
  logic               lk_kill;
  logic [PFN_W-1:0]   pfn_sel;
  perm_t              perm_sel;

  // parallel comparators: lookup, fill, invalidate
  xlc_match #(.N(ENTRIES), .VW(VPN_W)) u_lk_cmp (
    .valid(valid_q), .tags(tag_q), .key(lk_vpn), .hit(hit_vec));
  xlc_match #(.N(ENTRIES), .VW(VPN_W)) u_fl_cmp (
    .valid(valid_q), .tags(tag_q), .key(fill_vpn), .hit(dup_vec));
  xlc_match #(.N(ENTRIES), .VW(VPN_W)) u_iv_cmp (
    .valid(valid_q), .tags(tag_q), .key(inv_vpn), .hit(kill_vec));

  xlc_first_one #(.N(ENTRIES), .IW(IW)) u_dup_enc (
    .req(dup_vec), .found(dup_found), .idx(dup_idx));
  xlc_first_one #(.N(ENTRIES), .IW(IW)) u_free_enc (
    .req(~valid_q), .found(free_found), .idx(free_idx));

  xlc_rr_victim #(.N(ENTRIES), .IW(IW)) u_rr (
    .clk(clk), .rst_n(rst_n), .advance(evict), .ptr(rr_ptr));

  // lookup result, same cycle
  assign lk_kill = root_wr || (inv_page && (inv_vpn == lk_vpn));
  assign lk_hit  = lk_valid && (|hit_vec) && !lk_kill;

  always_comb begin
    pfn_sel  = '0;
    perm_sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        pfn_sel  = pfn_sel | pfn_q[i];
        perm_sel = perm_sel | perm_q[i];
      end
    end
  end

  assign lk_pfn = lk_hit ? pfn_sel : '0;
  assign lk_wr  = lk_hit && perm_sel.wr;
  assign lk_usr = lk_hit && perm_sel.usr;

  // fill slot choice
  assign fill_ready = !(inv_page || root_wr);
  assign fill_fire  = fill_valid && fill_ready;

  always_comb begin
    if (dup_found)       kind = SLOT_SAME;
    else if (free_found) kind = SLOT_FREE;
    else                 kind = SLOT_EVICT;
    case (kind)
      SLOT_SAME: tgt = dup_idx;
      SLOT_FREE: tgt = free_idx;
      default:   tgt = rr_ptr;
    endcase
  end

  assign evict = fill_fire && (kind == SLOT_EVICT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (root_wr) begin
      valid_q <= '0;
    end else if (inv_page) begin
      valid_q <= valid_q & ~kill_vec;
    end else if (fill_fire) begin
      valid_q[tgt] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_fire) begin
      tag_q[tgt]      <= fill_vpn;
      pfn_q[tgt]      <= fill_pfn;
      perm_q[tgt].wr  <= fill_wr;
      perm_q[tgt].usr <= fill_usr;
    end
  end
endmodule

// File: rtl/xlc_tlb_chk.sv
module xlc_tlb_chk #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [VPN_W-1:0]   lk_vpn,
  input logic               lk_hit,
  input logic [PFN_W-1:0]   lk_pfn,
  input logic               fill_valid,
  input logic               fill_ready,
  input logic [VPN_W-1:0]   fill_vpn,
  input logic [PFN_W-1:0]   fill_pfn,
  input logic               inv_page,
  input logic [VPN_W-1:0]   inv_vpn,
  input logic               root_wr,
  input logic [ENTRIES-1:0] hit_vec
);
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lk_hit);

  p_fill_then_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(rst_n && fill_valid && fill_ready) &&
     lk_vpn == $past(fill_vpn) && !inv_page && !root_wr)
    |-> (lk_hit && lk_pfn == $past(fill_pfn)));

  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_pfn == '0);

  p_single_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    root_wr |=> !lk_hit);

  p_inv_same_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_page && lk_valid && inv_vpn == lk_vpn) |-> !lk_hit);

  p_fill_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_page || root_wr) |-> !fill_ready);
endmodule

bind xlc_tlb xlc_tlb_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
  .lk_hit(lk_hit), .lk_pfn(lk_pfn), .fill_valid(fill_valid),
  .fill_ready(fill_ready), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
  .inv_page(inv_page), .inv_vpn(inv_vpn), .root_wr(root_wr),
  .hit_vec(hit_vec));

// File: tb/sim_xlc_tlb.sv
module sim_xlc_tlb;
  localparam int PERIOD = 10;
  localparam int NE = 4;
  localparam int NK = 10;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, lk_hit, lk_wr, lk_usr;
  logic [19:0] lk_vpn = 0, lk_pfn;
  logic fill_valid = 0, fill_ready, fill_wr = 0, fill_usr = 0;
  logic [19:0] fill_vpn = 0, fill_pfn = 0;
  logic inv_page = 0, root_wr = 0;
  logic [19:0] inv_vpn = 0;

  int total = 0, bad = 0;
  bit done = 0;

  logic        mv [NE];
  logic [19:0] mt [NE];
  logic [19:0] mp [NE];
  logic        mw [NE];
  logic        mu [NE];
  int          mptr = 0;

  always #(PERIOD/2) clk = ~clk;

  xlc_tlb #(.ENTRIES(NE)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_wr(lk_wr), .lk_usr(lk_usr),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_wr(fill_wr), .fill_usr(fill_usr),
    .inv_page(inv_page), .inv_vpn(inv_vpn), .root_wr(root_wr));

  function automatic logic [19:0] key(int k);
    return 20'hA0000 + 20'(k * 17);
  endfunction

  function automatic int mfind(logic [19:0] v);
    for (int i = 0; i < NE; i++) if (mv[i] && mt[i] == v) return i;
    return -1;
  endfunction

  task automatic chk(string req, bit ok, logic [19:0] v, logic [23:0] act, logic [23:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s vpn=%h act=%h exp=%h", req, v, act, exp);
    end
  endtask

  task automatic sweep(string req);
    for (int k = 0; k < NK; k++) begin
      int e;
      logic [23:0] ex, ac;
      lk_valid = 1;
      lk_vpn = key(k);
      #1;
      e = mfind(key(k));
      ex = (e < 0) ? 24'h0 : {1'b1, mw[e], mu[e], 1'b0, mp[e]};
      ac = {lk_hit, lk_wr, lk_usr, 1'b0, lk_pfn};
      chk(req, ac == ex, key(k), ac, ex);
    end
    lk_valid = 0;
  endtask

  task automatic fill(logic [19:0] v, logic [19:0] p, logic w, logic u);
    @(posedge clk); #1;
    fill_valid = 1; fill_vpn = v; fill_pfn = p; fill_wr = w; fill_usr = u;
    @(posedge clk);
    begin
      int e, f;
      e = mfind(v);
      if (e < 0) begin
        f = -1;
        for (int i = NE - 1; i >= 0; i--) if (!mv[i]) f = i;
        if (f < 0) begin f = mptr; mptr = (mptr + 1) % NE; end
        e = f;
      end
      mv[e] = 1; mt[e] = v; mp[e] = p; mw[e] = w; mu[e] = u;
    end
    #1 fill_valid = 0;
  endtask

  task automatic inval(logic [19:0] v);
    @(posedge clk); #1;
    inv_page = 1; inv_vpn = v;
    @(posedge clk);
    for (int i = 0; i < NE; i++) if (mv[i] && mt[i] == v) mv[i] = 0;
    #1 inv_page = 0;
  endtask

  task automatic flush();
    @(posedge clk); #1;
    root_wr = 1;
    @(posedge clk);
    for (int i = 0; i < NE; i++) mv[i] = 0;
    #1 root_wr = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) mv[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    sweep("R1");
    // R2 R4: fill free entries, earlier ones stay
    for (int k = 0; k < NE; k++) begin
      fill(key(k), 20'h10000 + 20'(k), k[0], k[1]);
      sweep("R4");
    end
    // R2: same-cycle result and lk_valid low
    lk_vpn = key(0); lk_valid = 0; #1;
    chk("R2", lk_hit == 0, key(0), 24'(lk_hit), 24'h0);
    // R6: refill existing page in place
    fill(key(2), 20'h5BEEF, 1, 1);
    sweep("R6");
    // R5: evictions in round-robin order, plus R3 misses in the sweep
    for (int k = NE; k < NE + 5; k++) begin
      fill(key(k), 20'h20000 + 20'(k), k[1], k[0]);
      sweep("R5");
    end
    // R7: remove a single page, then refill lands in free slot
    inval(key(6));
    sweep("R7");
    fill(key(9), 20'h3AAAA, 0, 1);
    sweep("R4");
    // R9 R10: same-cycle invalidate, lookup and blocked fill
    @(posedge clk); #1;
    inv_page = 1; inv_vpn = key(8); fill_valid = 1; fill_vpn = key(1);
    fill_pfn = 20'h77777; lk_valid = 1; lk_vpn = key(8); #1;
    chk("R9", lk_hit == 0, key(8), 24'(lk_hit), 24'h0);
    chk("R10", fill_ready == 0, key(1), 24'(fill_ready), 24'h0);
    lk_vpn = key(9); #1;
    chk("R9", lk_hit == (mfind(key(9)) >= 0), key(9), 24'(lk_hit), 24'(mfind(key(9)) >= 0));
    @(posedge clk);
    for (int i = 0; i < NE; i++) if (mv[i] && mt[i] == key(8)) mv[i] = 0;
    #1 inv_page = 0; fill_valid = 0; lk_valid = 0;
    sweep("R10");
    // R9: lookup during root rewrite misses
    @(posedge clk); #1;
    root_wr = 1; lk_valid = 1; lk_vpn = key(9); #1;
    chk("R9", lk_hit == 0, key(9), 24'(lk_hit), 24'h0);
    @(posedge clk);
    for (int i = 0; i < NE; i++) mv[i] = 0;
    #1 root_wr = 0; lk_valid = 0;
    sweep("R8");
    // longer mix after flush: pointer keeps rotating
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < NK; k++) begin
        fill(key((k * 3 + r) % NK), 20'h40000 + 20'(k * 5 + r), r[0], k[0]);
        sweep("R5");
      end
      inval(key(r));
      sweep("R7");
    end
    flush();
    sweep("R8");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule